// File: doc/BRIEF.md
# Dual-Window GPIO Port Register File

This block is a general-purpose I/O port of up to eight pins that sits behind a plain byte-wide register bus. Software reaches it through two address windows that share one set of state. The wide window holds the direction, output latch, input readback, event flags and one control register per pin. It also has write-one set, clear and toggle strobes for both the direction and output latches. The narrow window holds only four registers that alias the same direction, output, input and flag state, so frequent pin updates need only a short address.

The pads are driven from the output latch and the direction latch, which acts as output enable. Pad inputs pass through a multi-flop synchronizer. That synchronized value feeds the input readback and a per-pin event detector. Each detector is driven by a sense code held in its pin's control register. The control registers also export a pull-up enable for each pin. A one-cycle pulse marks every bus write that leaves the output latch at a new value.

Top module: `gpio_dv_port`

## Requirements
- R1: After reset the direction, output, flag and all pin control registers read 0x00, so `pad_oe`, `pad_out`, `pull_en`, `sense_code` and `out_changed` are all zero.
- R2: The direction latch is written at wide offset 0x00 or narrow offset 0x00. Both offsets read back the same value. `pad_oe` equals the latch, and the latch holds when no direction write occurs.
- R3: The output latch is written at wide offset 0x04 or narrow offset 0x01. Both offsets read back the same value. `pad_out` equals the latch, and the latch holds when no output write occurs.
- R4: Writes to wide offsets 0x01/0x05 OR the data into direction/output, writes to 0x02/0x06 clear the bits written as 1, and writes to 0x03/0x07 XOR the data in.
- R5: The input value is read at wide offset 0x08 or narrow offset 0x02. Each bit returns the output latch bit if its direction bit is 1, and otherwise the pad input delayed by two clock edges through the synchronizer.
- R6: Pin n's control register sits at wide offset 0x10+n and keeps only bits 3:0. Bit 3 drives `pull_en[n]`, and bits 2:0 appear as `sense_code[3n+2:3n]`. Bits 7:4 read as 0.
- R7: A flag bit, read at wide 0x09 or narrow 0x03, is set when the pin's input value (as read in R5) matches its sense code compared with its value one edge earlier. The codes are: 1 = any change, 2 = rise, 3 = fall, 5 = while low. Codes 0, 4, 6 and 7 never set a flag.
- R8: Writing 1s to either flag offset clears those flag bits. A flag that is set and cleared at the same edge stays set.
- R9: `out_changed` is high for exactly the one cycle after an edge at which a write changed the output latch. It stays low after a write that leaves the latch unchanged.
- R10: Reads of offsets 0x01–0x03, 0x05–0x07, 0x0A–0x0F and 0x18 and up in the wide window, of narrow offsets 4 and above, and with no window selected return 0x00. Writes there, or to the input offsets, change no state. If both windows are selected, the wide window wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_full | input | 1 | Selects the wide window |
| bus_sel_fast | input | 1 | Selects the narrow window |
| bus_addr | input | ADDR_W | Register offset within the selected window |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the current offset |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output latch to the pads |
| pad_oe | output | NUM_PINS | Output enable per pin (direction latch) |
| pull_en | output | NUM_PINS | Pull-up enable per pin |
| sense_code | output | 3*NUM_PINS | Sense code per pin, pin n in bits 3n+2:3n |
| out_changed | output | 1 | One-cycle pulse after the output latch changes |

## Verification
The bench builds the port with eight pins and a two-stage synchronizer. With these values every pin control offset up to 0x17 decodes, the bus byte is fully used, and the input latency is a fixed two edges. That fixed latency lets directed checks sample the readback just before and just after a pad change arrives. The random phase drives both window selects at once, writes with every alias strobe, and toggles pads under every sense code. Level-low flags then collide with write-one clears, and output writes repeat the current latch value.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;

   localparam int MAX_PINS   = 8;

   // wide-window offsets
   localparam int W_DIR      = 'h00;
   localparam int W_DIR_SET  = 'h01;
   localparam int W_DIR_CLR  = 'h02;
   localparam int W_DIR_TGL  = 'h03;
   localparam int W_OUT      = 'h04;
   localparam int W_OUT_SET  = 'h05;
   localparam int W_OUT_CLR  = 'h06;
   localparam int W_OUT_TGL  = 'h07;
   localparam int W_IN       = 'h08;
   localparam int W_FLAG     = 'h09;
   localparam int W_CTRL0    = 'h10;

   // narrow-window offsets
   localparam int N_DIR      = 0;
   localparam int N_OUT      = 1;
   localparam int N_IN       = 2;
   localparam int N_FLAG     = 3;

   typedef enum logic [2:0] {
      SNS_OFF  = 3'd0,
      SNS_ANY  = 3'd1,
      SNS_RISE = 3'd2,
      SNS_FALL = 3'd3,
      SNS_LOW  = 3'd5
   } sense_e;

   typedef enum logic [2:0] {
      RD_ZERO, RD_DIR, RD_OUT, RD_IN, RD_FLAG, RD_CTRL
   } rd_sel_e;

   typedef struct packed {
      logic                dir_wr;
      logic                dir_set;
      logic                dir_clr;
      logic                dir_tgl;
      logic                out_wr;
      logic                out_set;
      logic                out_clr;
      logic                out_tgl;
      logic                flag_clr;
      logic [MAX_PINS-1:0] ctrl_wr;
   } wr_strb_t;

endpackage

// File: rtl/gpio_dv_sync.sv
module gpio_dv_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_dv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_dv_decode.sv
module gpio_dv_decode
   import gpio_dv_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 5
) (
   input  logic              sel_full,
   input  logic              sel_fast,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output wr_strb_t          wr,
   output rd_sel_e           rd,
   output logic [2:0]        ctrl_idx
);

   localparam int CTRL_END = W_CTRL0 + NUM_PINS;

   always_comb begin
      wr       = '0;
      rd       = RD_ZERO;
      ctrl_idx = addr[2:0];
      if (sel_full) begin
         case (int'(addr))
            W_DIR:     begin rd = RD_DIR;  wr.dir_wr = we; end
            W_DIR_SET: wr.dir_set = we;
            W_DIR_CLR: wr.dir_clr = we;
            W_DIR_TGL: wr.dir_tgl = we;
            W_OUT:     begin rd = RD_OUT;  wr.out_wr = we; end
            W_OUT_SET: wr.out_set = we;
            W_OUT_CLR: wr.out_clr = we;
            W_OUT_TGL: wr.out_tgl = we;
            W_IN:      rd = RD_IN;
            W_FLAG:    begin rd = RD_FLAG; wr.flag_clr = we; end
            default: begin
               if (int'(addr) >= W_CTRL0 && int'(addr) < CTRL_END) begin
                  rd = RD_CTRL;
                  wr.ctrl_wr[addr[2:0]] = we;
               end
            end
         endcase
      end else if (sel_fast) begin
         case (int'(addr))
            N_DIR:   begin rd = RD_DIR;  wr.dir_wr = we; end
            N_OUT:   begin rd = RD_OUT;  wr.out_wr = we; end
            N_IN:    rd = RD_IN;
            N_FLAG:  begin rd = RD_FLAG; wr.flag_clr = we; end
            default: rd = RD_ZERO;
         endcase
      end
   end

endmodule

// File: rtl/gpio_dv_sense.sv
module gpio_dv_sense
   import gpio_dv_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   in_now,
   input  logic [3*NUM_PINS-1:0] codes,
   output logic [NUM_PINS-1:0]   hit
);

   logic [NUM_PINS-1:0] in_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_prev_q <= '0;
      else        in_prev_q <= in_now;
   end

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_det
         always_comb begin
            case (codes[3*p +: 3])
               SNS_ANY:  hit[p] = in_now[p] ^ in_prev_q[p];
               SNS_RISE: hit[p] = in_now[p] & ~in_prev_q[p];
               SNS_FALL: hit[p] = ~in_now[p] & in_prev_q[p];
               SNS_LOW:  hit[p] = ~in_now[p];
               default:  hit[p] = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_dv_port.sv
module gpio_dv_port
   import gpio_dv_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel_full,
   input  logic                  bus_sel_fast,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pull_en,
   output logic [3*NUM_PINS-1:0] sense_code,
   output logic                  out_changed
);

   localparam int CTRL_W = 4;

   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
         $error("gpio_dv_port: NUM_PINS must be 1..8");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("gpio_dv_port: ADDR_W must reach the control offsets");
      end
   endgenerate

   wr_strb_t                          wr;
   rd_sel_e                           rd;
   logic [2:0]                        ctrl_idx;
   logic [NUM_PINS-1:0]               wd;
   logic [NUM_PINS-1:0]               dir_q, dir_d;
   logic [NUM_PINS-1:0]               out_q, out_d;
   logic [NUM_PINS-1:0]               flag_q, flag_d;
   logic [NUM_PINS-1:0]               sync_in, in_now, hit;
   logic [NUM_PINS-1:0][CTRL_W-1:0]   ctrl_q;
   logic                              chg_q;

   assign wd = bus_wdata[NUM_PINS-1:0];

   gpio_dv_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
      .sel_full (bus_sel_full),
      .sel_fast (bus_sel_fast),
      .we       (bus_we),
      .addr     (bus_addr),
      .wr       (wr),
      .rd       (rd),
      .ctrl_idx (ctrl_idx)
   );

   gpio_dv_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pad_in),
      .q_sync  (sync_in)
   );

   assign in_now = (dir_q & out_q) | (~dir_q & sync_in);

   gpio_dv_sense #(.NUM_PINS(NUM_PINS)) u_sense (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_now (in_now),
      .codes  (sense_code),
      .hit    (hit)
   );

   always_comb begin
      dir_d = dir_q;
      if (wr.dir_wr)  dir_d = wd;
      if (wr.dir_set) dir_d = dir_q | wd;
      if (wr.dir_clr) dir_d = dir_q & ~wd;
      if (wr.dir_tgl) dir_d = dir_q ^ wd;
      out_d = out_q;
      if (wr.out_wr)  out_d = wd;
      if (wr.out_set) out_d = out_q | wd;
      if (wr.out_clr) out_d = out_q & ~wd;
      if (wr.out_tgl) out_d = out_q ^ wd;
      flag_d = (flag_q & ~(wr.flag_clr ? wd : '0)) | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         flag_q <= '0;
         chg_q  <= 1'b0;
         ctrl_q <= '0;
      end else begin
         dir_q  <= dir_d;
         out_q  <= out_d;
         flag_q <= flag_d;
         chg_q  <= (out_d != out_q);
         for (int p = 0; p < NUM_PINS; p++) begin
            if (wr.ctrl_wr[p]) ctrl_q[p] <= bus_wdata[CTRL_W-1:0];
         end
      end
   end

   always_comb begin
      case (rd)
         RD_DIR:  bus_rdata = 8'(dir_q);
         RD_OUT:  bus_rdata = 8'(out_q);
         RD_IN:   bus_rdata = 8'(in_now);
         RD_FLAG: bus_rdata = 8'(flag_q);
         RD_CTRL: bus_rdata = 8'(ctrl_q[ctrl_idx]);
         default: bus_rdata = 8'h00;
      endcase
   end

   assign pad_out     = out_q;
   assign pad_oe      = dir_q;
   assign out_changed = chg_q;

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         assign pull_en[p]          = ctrl_q[p][3];
         assign sense_code[3*p +: 3] = ctrl_q[p][2:0];

         AST_FLAG_NEEDS_SENSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_q[p]) |-> ($past(ctrl_q[p][2:0]) != 3'd0)); // R7
      end
   endgenerate

   AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !(wr.dir_wr || wr.dir_set || wr.dir_clr || wr.dir_tgl) |=> $stable(pad_oe)); // R2
   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !(wr.out_wr || wr.out_set || wr.out_clr || wr.out_tgl) |=> $stable(pad_out)); // R3
   AST_CHG_MEANS_MOVE: assert property (@(posedge clk) disable iff (!rst_n) out_changed |-> (pad_out != $past(pad_out))); // R9
   AST_STILL_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (pad_out == $past(pad_out)) |-> !out_changed); // R9
   AST_FLAG_CLR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr.flag_clr |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R8

endmodule

// File: tb/gpio_dv_port_tb.sv
module gpio_dv_port_tb;

   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          b_full = 1'b0, b_fast = 1'b0, b_we = 1'b0;
   logic [4:0]    b_addr = '0;
   logic [7:0]    b_wdata = '0;
   logic [7:0]    rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pull_en;
   logic [3*NP-1:0] sense_code;
   logic          out_changed;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_dv_port #(.NUM_PINS(NP), .SYNC_STAGES(2), .ADDR_W(5)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel_full(b_full), .bus_sel_fast(b_fast),
      .bus_addr(b_addr), .bus_we(b_we), .bus_wdata(b_wdata), .bus_rdata(rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
      .sense_code(sense_code), .out_changed(out_changed)
   );

   // behavioural reference
   logic [7:0] m_dir, m_out, m_flag, m_prev, m_s1, m_s2;
   logic [3:0] m_ctrl [NP];
   logic       m_chg;

   always @(posedge clk or negedge rst_n) begin : model
      logic [7:0] inv, hits, nd, no, clr;
      int a;
      if (!rst_n) begin
         m_dir = 0; m_out = 0; m_flag = 0; m_prev = 0; m_s1 = 0; m_s2 = 0; m_chg = 0;
         for (int i = 0; i < NP; i++) m_ctrl[i] = 0;
      end else begin
         inv = (m_dir & m_out) | (~m_dir & m_s2);
         hits = 0;
         for (int i = 0; i < NP; i++) begin
            case (m_ctrl[i][2:0])
               3'd1: hits[i] = inv[i] != m_prev[i];
               3'd2: hits[i] = inv[i] && !m_prev[i];
               3'd3: hits[i] = !inv[i] && m_prev[i];
               3'd5: hits[i] = !inv[i];
               default: hits[i] = 0;
            endcase
         end
         nd = m_dir; no = m_out; clr = 0; a = int'(b_addr);
         if (b_we && b_full) begin
            if (a == 0) nd = b_wdata;
            else if (a == 1) nd = m_dir | b_wdata;
            else if (a == 2) nd = m_dir & ~b_wdata;
            else if (a == 3) nd = m_dir ^ b_wdata;
            else if (a == 4) no = b_wdata;
            else if (a == 5) no = m_out | b_wdata;
            else if (a == 6) no = m_out & ~b_wdata;
            else if (a == 7) no = m_out ^ b_wdata;
            else if (a == 9) clr = b_wdata;
            else if (a >= 16 && a < 16 + NP) m_ctrl[a-16] = b_wdata[3:0];
         end else if (b_we && b_fast) begin
            if (a == 0) nd = b_wdata;
            else if (a == 1) no = b_wdata;
            else if (a == 3) clr = b_wdata;
         end
         m_chg  = (no != m_out);
         m_flag = (m_flag & ~clr) | hits;
         m_prev = inv;
         m_s2 = m_s1; m_s1 = pad_in;
         m_dir = nd; m_out = no;
      end
   end

   function automatic logic [7:0] m_read();
      int a = int'(b_addr);
      logic [7:0] inv = (m_dir & m_out) | (~m_dir & m_s2);
      if (b_full) begin
         if (a == 0) return m_dir;
         if (a == 4) return m_out;
         if (a == 8) return inv;
         if (a == 9) return m_flag;
         if (a >= 16 && a < 16 + NP) return {4'b0, m_ctrl[a-16]};
         return 8'h00;
      end
      if (b_fast) begin
         if (a == 0) return m_dir;
         if (a == 1) return m_out;
         if (a == 2) return inv;
         if (a == 3) return m_flag;
      end
      return 8'h00;
   endfunction

   function automatic string m_tag();
      int a = int'(b_addr);
      if (b_full) begin
         if (a == 0) return "R2";
         if (a == 4) return "R3";
         if (a == 8) return "R5";
         if (a == 9) return "R7";
         if (a >= 16 && a < 24) return "R6";
      end else if (b_fast && a < 4) begin
         if (a == 0) return "R2";
         if (a == 1) return "R3";
         if (a == 2) return "R5";
         return "R7";
      end
      return "R10";
   endfunction

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag, input string what);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
      end
   endtask

   // continuous comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         logic [23:0] sc;
         logic [7:0]  pe;
         for (int i = 0; i < NP; i++) begin
            sc[3*i +: 3] = m_ctrl[i][2:0];
            pe[i] = m_ctrl[i][3];
         end
         chk(pad_out, m_out, "R3", "pad_out");
         chk(pad_oe, m_dir, "R2", "pad_oe");
         chk(pull_en, pe, "R6", "pull_en");
         chk(sense_code, sc, "R6", "sense_code");
         chk(out_changed, m_chg, "R9", "out_changed");
         chk(rdata, m_read(), m_tag(), "bus_rdata");
      end
   end

   task automatic bwr(input bit fast, input int a, input logic [7:0] d);
      @(negedge clk);
      b_full = !fast; b_fast = fast; b_addr = 5'(a); b_we = 1'b1; b_wdata = d;
      @(negedge clk);
      b_we = 1'b0; b_full = 1'b0; b_fast = 1'b0;
   endtask

   task automatic brd(input bit fast, input int a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      b_full = !fast; b_fast = fast; b_addr = 5'(a); b_we = 1'b0;
      #2;
      chk(rdata, exp, tag, "directed read");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      brd(0, 'h00, 8'h00, "R1");
      brd(0, 'h04, 8'h00, "R1");
      brd(0, 'h09, 8'h00, "R1");
      brd(0, 'h17, 8'h00, "R1");
      chk(pad_oe, 0, "R1", "pad_oe reset");
      chk(pull_en, 0, "R1", "pull_en reset");
      chk(out_changed, 0, "R1", "out_changed reset");
      // R2 direction through both windows
      bwr(0, 'h00, 8'h0F); brd(1, 0, 8'h0F, "R2");
      bwr(1, 0, 8'hA5);    brd(0, 'h00, 8'hA5, "R2");
      chk(pad_oe, 8'hA5, "R2", "pad_oe");
      // R4 direction aliases
      bwr(0, 'h01, 8'h50); brd(0, 'h00, 8'hF5, "R4");
      bwr(0, 'h02, 8'h05); brd(0, 'h00, 8'hF0, "R4");
      bwr(0, 'h03, 8'hFF); brd(1, 0, 8'h0F, "R4");
      // R3 / R9 output latch and change pulse
      bwr(0, 'h04, 8'h33); #2 chk(out_changed, 1, "R9", "pulse on change");
      brd(1, 1, 8'h33, "R3");
      bwr(0, 'h04, 8'h33); #2 chk(out_changed, 0, "R9", "no pulse on same value");
      bwr(0, 'h05, 8'h0C); brd(0, 'h04, 8'h3F, "R4");
      bwr(0, 'h06, 8'h30); brd(0, 'h04, 8'h0F, "R4");
      bwr(0, 'h07, 8'hFF); brd(0, 'h04, 8'hF0, "R4");
      bwr(1, 1, 8'h5A);    chk(pad_out, 8'h5A, "R3", "pad_out");
      // R5 input readback and sync latency
      @(negedge clk); pad_in = 8'hC3;
      repeat (3) @(negedge clk);
      brd(0, 'h08, 8'hCA, "R5");
      @(negedge clk); pad_in = 8'h03;
      brd(1, 2, 8'hCA, "R5");
      brd(1, 2, 8'h0A, "R5");
      // R6 / R7 sense and flags
      bwr(0, 'h00, 8'h00);
      bwr(0, 'h14, 8'h0A);
      bwr(0, 'h15, 8'h03);
      bwr(0, 'h16, 8'h01);
      bwr(0, 'h17, 8'h05);
      chk(pull_en, 8'h10, "R6", "pull_en pin4");
      chk(sense_code, 24'hA5A000, "R6", "sense codes");
      bwr(0, 'h14, 8'hFA); brd(0, 'h14, 8'h0A, "R6");
      @(negedge clk); pad_in = 8'h73;
      repeat (4) @(negedge clk);
      brd(0, 'h09, 8'hD0, "R7");
      @(negedge clk); pad_in = 8'h03;
      repeat (4) @(negedge clk);
      brd(1, 3, 8'hF0, "R7");
      // R8 write-one clear, set wins
      bwr(1, 3, 8'h30);    brd(0, 'h09, 8'hC0, "R8");
      bwr(0, 'h09, 8'hFF); brd(0, 'h09, 8'h80, "R8");
      bwr(0, 'h17, 8'h00);
      bwr(0, 'h09, 8'h80); brd(0, 'h09, 8'h00, "R8");
      // R7 unused code never flags
      bwr(0, 'h14, 8'h04);
      bwr(0, 'h16, 8'h00);
      bwr(0, 'h15, 8'h00);
      @(negedge clk); pad_in = 8'h13;
      repeat (4) @(negedge clk); pad_in = 8'h03;
      repeat (4) @(negedge clk);
      brd(0, 'h09, 8'h00, "R7");
      // R10 aliases, holes, writes to IN
      brd(0, 'h01, 8'h00, "R10");
      brd(0, 'h06, 8'h00, "R10");
      brd(0, 'h0A, 8'h00, "R10");
      brd(0, 'h18, 8'h00, "R10");
      brd(1, 4, 8'h00, "R10");
      bwr(0, 'h08, 8'hFF); brd(0, 'h00, 8'h00, "R10");
      bwr(1, 2, 8'hFF);    brd(1, 1, 8'h5A, "R10");
      bwr(0, 'h0C, 8'hFF); brd(0, 'h04, 8'h5A, "R10");
      // random phase, compared every cycle by the model
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         b_full  = ($urandom % 3) != 0;
         b_fast  = ($urandom % 2) != 0;
         b_we    = ($urandom % 2) != 0;
         b_addr  = ($urandom % 3 == 0) ? 5'($urandom % 4) : 5'($urandom);
         b_wdata = 8'($urandom);
         if ($urandom % 3 == 0) pad_in = 8'($urandom);
      end
      @(negedge clk);
      b_we = 0; b_full = 0; b_fast = 0;
      repeat (3) @(negedge clk);
      #3;
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule